// File: doc/BRIEF.md
# Timer with Compare-Match Pin Action

An 8-bit free-running counter with one compare channel, controlled through a small synchronous register bus. The block reports two kinds of timer event, counter wrap and compare match. Each event is reported in three ways at once. First, each event latches a sticky flag that software can poll. Second, the flags pass through a mask and a global enable to drive an interrupt request. Third, a compare match can set, clear or toggle an output pin with no software involvement.

Software controls the block through six registers: control, counter, compare, mask, flags and direction. Reads return data one clock after the address is presented. The flags are cleared by writing ones to them. The pin is driven only when its direction bit selects output.

Top module: `tmr_cmp_top`

## Requirements
- R1: After synchronous reset every register reads 0, and `irq`, `cmp_out` and `cmp_oe` are 0.
- R2: The counter adds one on each clock while the run bit (control bit 0) is 1, holds its value while that bit is 0, and wraps from 255 to 0.
- R3: The wrap from 255 to 0 sets flag bit 0. Software can see this flag by reading the flags register while no interrupt is enabled, and `irq` stays 0.
- R4: A compare match sets flag bit 1. A match is any clock in which the counter is running and equals the compare register.
- R5: Writing the flags register clears each flag whose write-data bit is 1. A write-data bit of 0 leaves its flag unchanged.
- R6: If an event sets a flag in the same clock in which software clears that flag, the flag stays set.
- R7: `irq` is 1 exactly when the global enable (control bit 1) is 1 and at least one flag is set whose mask bit (same position as the flag) is 1.
- R8: Control bits [3:2] select the pin action on a match: 01 toggles the pin, 10 clears it, 11 sets it. With 00 the pin is disconnected, so `cmp_out` is 0 and the pin state does not change on a match.
- R9: `cmp_oe` follows bit 0 of the direction register. When it is 0 the pin is left undriven.
- R10: A write to the counter register loads the written value in place of the increment. Any compare match in that clock is suppressed: no flag is set and the pin does not change.
- R11: The register addresses are control 0, counter 1, compare 2, mask 3, flags 4 and direction 5. Read data is registered one clock after the address. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| cmp_out | output | 1 | Compare pin level |
| cmp_oe | output | 1 | Compare pin drive enable (0 = undriven) |

## Verification
Two pairs of functions can fall in the same clock. A hardware event can set a flag while software writes a one to clear it. A software load of the counter can land in the very clock in which the counter equals the compare value. The bench runs the counter from a known start, so that the bus write lands on the edge where the match occurs. It then judges the result from the flags register read-back and from `cmp_out`: the flag must survive the clear, and the load must leave both the match flag and the pin untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_CMP   = 3'd2,
    A_MASK  = 3'd3,
    A_FLAG  = 3'd4,
    A_DIR   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_OFF = 2'b00,
    PIN_TOG = 2'b01,
    PIN_CLR = 2'b10,
    PIN_SET = 2'b11
  } pin_mode_e;

  localparam int EV_OVF   = 0;
  localparam int EV_CMP   = 1;
  localparam int NUM_EV   = 2;
  localparam int RUN_BIT  = 0;
  localparam int GIE_BIT  = 1;
  localparam int MODE_LSB = 2;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run,
  output logic              gie,
  output pin_mode_e         mode,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [NUM_EV-1:0] mask,
  output logic              dir_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      gie     <= 1'b0;
      mode    <= PIN_OFF;
      cmp_val <= '0;
      mask    <= '0;
      dir_oe  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): begin
          run  <= wr_data[RUN_BIT];
          gie  <= wr_data[GIE_BIT];
          mode <= pin_mode_e'(wr_data[MODE_LSB +: 2]);
        end
        ADDR_W'(A_CMP):  cmp_val <= wr_data[CNT_W-1:0];
        ADDR_W'(A_MASK): mask    <= wr_data[NUM_EV-1:0];
        ADDR_W'(A_DIR):  dir_oe  <= wr_data[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_ovf,
  output logic             ev_cmp
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // events are qualified by run and masked by a software load
  assign ev_ovf = run && !load && (cnt == CNT_MAX);
  assign ev_cmp = run && !load && (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int NUM_EV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              clr_en,
  input  logic [NUM_EV-1:0] clr_mask,
  input  logic [NUM_EV-1:0] mask,
  input  logic              gie,
  output logic [NUM_EV-1:0] flags,
  output logic              irq
);
  logic [NUM_EV-1:0] flags_n;

  always_comb begin
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev[i])                       flags_n[i] = 1'b1;  // set beats clear
      else if (clr_en && clr_mask[i])  flags_n[i] = 1'b0;
      else                             flags_n[i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_n;
  end

  assign irq = gie && (|(flags & mask));
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      match,
  input  pin_mode_e mode,
  input  logic      dir_oe,
  output logic      pin_state,
  output logic      pin_out,
  output logic      pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) pin_state <= 1'b0;
    else if (match) begin
      case (mode)
        PIN_TOG: pin_state <= ~pin_state;
        PIN_CLR: pin_state <= 1'b0;
        PIN_SET: pin_state <= 1'b1;
        default: ;
      endcase
    end
  end

  assign pin_out = (mode != PIN_OFF) && pin_state;
  assign pin_oe  = dir_oe;
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              cmp_out,
  output logic              cmp_oe
);
  logic              run_q, gie_q, dir_q, pin_q;
  pin_mode_e         mode_q;
  logic [CNT_W-1:0]  cmp_q, cnt_q;
  logic [NUM_EV-1:0] mask_q, flag_q, ev;
  logic              ev_ovf, ev_cmp;
  logic              cnt_wr, flag_wr;

  assign cnt_wr  = bus_we && (bus_addr == ADDR_W'(A_COUNT));
  assign flag_wr = bus_we && (bus_addr == ADDR_W'(A_FLAG));

  tmr_ctrl_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .run(run_q), .gie(gie_q), .mode(mode_q), .cmp_val(cmp_q), .mask(mask_q), .dir_oe(dir_q)
  );

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .run(run_q), .load(cnt_wr), .load_val(bus_wdata[CNT_W-1:0]),
    .cmp_val(cmp_q), .cnt(cnt_q), .ev_ovf(ev_ovf), .ev_cmp(ev_cmp)
  );

  always_comb begin
    ev         = '0;
    ev[EV_OVF] = ev_ovf;
    ev[EV_CMP] = ev_cmp;
  end

  tmr_flags #(.NUM_EV(NUM_EV)) flags_i (
    .clk(clk), .rst(rst), .ev(ev), .clr_en(flag_wr), .clr_mask(bus_wdata[NUM_EV-1:0]),
    .mask(mask_q), .gie(gie_q), .flags(flag_q), .irq(irq)
  );

  tmr_pin pin_i (
    .clk(clk), .rst(rst), .match(ev_cmp), .mode(mode_q), .dir_oe(dir_q),
    .pin_state(pin_q), .pin_out(cmp_out), .pin_oe(cmp_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        ADDR_W'(A_CTRL):  bus_rdata <= DATA_W'({mode_q, gie_q, run_q});
        ADDR_W'(A_COUNT): bus_rdata <= DATA_W'(cnt_q);
        ADDR_W'(A_CMP):   bus_rdata <= DATA_W'(cmp_q);
        ADDR_W'(A_MASK):  bus_rdata <= DATA_W'(mask_q);
        ADDR_W'(A_FLAG):  bus_rdata <= DATA_W'(flag_q);
        ADDR_W'(A_DIR):   bus_rdata <= DATA_W'(dir_q);
        default:          bus_rdata <= '0;
      endcase
    end
  end
endmodule

module tmr_cmp_chk #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic [1:0]        mode,
  input logic [1:0]        flags,
  input logic              irq,
  input logic              pin,
  input logic              oe
);
  logic cnt_wr, flg_wr, hit;
  assign cnt_wr = we && (addr == ADDR_W'(1));
  assign flg_wr = we && (addr == ADDR_W'(4));
  assign hit    = run && !cnt_wr && (cnt == cmp);

  // R2
  count_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R3
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr && (cnt == {CNT_W{1'b1}})) |=> flags[0]);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && flg_wr && wdata[1]) |=> flags[1]);
  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_wr && wdata[1] && !hit) |=> !flags[1]);
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_wr && (&wdata[1:0]) && !run) |=> !irq);
  // R8
  set_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && (mode == 2'b11)) |=> pin);
  // R10
  load_nomatch_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> ($stable(pin) && (cnt == $past(wdata[CNT_W-1:0]))));
  // R9
  dir_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (we && (addr == ADDR_W'(5))) |=> (oe == $past(wdata[0])));
endmodule

bind tmr_cmp_top tmr_cmp_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
  .run(run_q), .cnt(cnt_q), .cmp(cmp_q), .mode(mode_q), .flags(flag_q),
  .irq(irq), .pin(pin_q), .oe(cmp_oe)
);

// File: tb/tmr_cmp_top_tb_top.sv
module tmr_cmp_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq, cmp_out, cmp_oe;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_cmp_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .irq(irq), .cmp_out(cmp_out), .cmp_oe(cmp_oe)
  );

  localparam logic [2:0] AD_CTRL = 3'd0, AD_CNT = 3'd1, AD_CMP = 3'd2,
                         AD_MASK = 3'd3, AD_FLAG = 3'd4, AD_DIR = 3'd5;

  // {mode[1:0], compare[7:0], expected cmp_out}
  localparam logic [10:0] VEC [8] = '{
    {2'b11, 8'd20,  1'b1},
    {2'b01, 8'd30,  1'b0},
    {2'b01, 8'd40,  1'b1},
    {2'b10, 8'd50,  1'b0},
    {2'b11, 8'd60,  1'b1},
    {2'b00, 8'd70,  1'b0},
    {2'b01, 8'd80,  1'b0},
    {2'b11, 8'd200, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic setctl(input logic run, input logic gie, input logic [1:0] mode);
    wr(AD_CTRL, {4'b0, mode, gie, run});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R11: reset values and register map
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg read", d, 8'h00);
    end
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 cmp_out", {7'b0, cmp_out}, 8'h00);
    check("R1 cmp_oe", {7'b0, cmp_oe}, 8'h00);

    // R9: direction bit
    wr(AD_DIR, 8'h01);
    check("R9 oe on", {7'b0, cmp_oe}, 8'h01);

    // R11: compare register read-back
    wr(AD_CMP, 8'h5A);
    rd(AD_CMP, d);
    check("R11 cmp readback", d, 8'h5A);

    // R8 / R4: vector table of pin actions
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      logic [7:0] c;
      m = VEC[i][10:9];
      c = VEC[i][8:1];
      setctl(1'b0, 1'b0, m);
      wr(AD_CMP, c);
      wr(AD_CNT, c - 8'd2);
      wr(AD_FLAG, 8'hFF);
      setctl(1'b1, 1'b0, m);
      repeat (3) @(negedge clk);
      check("R8 pin action", {7'b0, cmp_out}, {7'b0, VEC[i][0]});
      setctl(1'b0, 1'b0, m);
      rd(AD_FLAG, d);
      check("R4 match flag", d, 8'h02);
    end

    // R2: increment and hold
    setctl(1'b0, 1'b0, 2'b00);
    wr(AD_CNT, 8'd10);
    setctl(1'b1, 1'b0, 2'b00);
    repeat (5) @(negedge clk);
    setctl(1'b0, 1'b0, 2'b00);
    rd(AD_CNT, d);
    check("R2 increment", d, 8'd16);
    repeat (4) @(negedge clk);
    rd(AD_CNT, d);
    check("R2 hold", d, 8'd16);

    // R2 / R3: wrap and polled overflow flag with interrupts off
    wr(AD_CNT, 8'd253);
    wr(AD_FLAG, 8'hFF);
    wr(AD_MASK, 8'h00);
    setctl(1'b1, 1'b0, 2'b00);
    repeat (3) @(negedge clk);
    setctl(1'b0, 1'b0, 2'b00);
    rd(AD_CNT, d);
    check("R2 wrap", d, 8'd1);
    rd(AD_FLAG, d);
    check("R3 overflow flag", d, 8'h01);
    check("R3 irq off", {7'b0, irq}, 8'h00);

    // R10: load in the match cycle
    setctl(1'b0, 1'b0, 2'b01);
    wr(AD_CMP, 8'd50);
    wr(AD_CNT, 8'd48);
    wr(AD_FLAG, 8'hFF);
    setctl(1'b1, 1'b0, 2'b01);
    repeat (2) @(negedge clk);
    wr(AD_CNT, 8'd100);
    rd(AD_CNT, d);
    check("R10 load value", d, 8'd100);
    check("R10 pin unchanged", {7'b0, cmp_out}, 8'h01);
    setctl(1'b0, 1'b0, 2'b01);
    rd(AD_FLAG, d);
    check("R10 no match flag", d, 8'h00);

    // R6: set beats clear
    setctl(1'b0, 1'b0, 2'b00);
    wr(AD_CMP, 8'd60);
    wr(AD_CNT, 8'd58);
    wr(AD_FLAG, 8'hFF);
    setctl(1'b1, 1'b0, 2'b00);
    repeat (2) @(negedge clk);
    wr(AD_FLAG, 8'h02);
    setctl(1'b0, 1'b0, 2'b00);
    rd(AD_FLAG, d);
    check("R6 set wins", d, 8'h02);

    // R5: writing 0 has no effect
    wr(AD_FLAG, 8'h00);
    rd(AD_FLAG, d);
    check("R5 zero write", d, 8'h02);

    // R7: interrupt gating
    wr(AD_MASK, 8'h00);
    setctl(1'b0, 1'b1, 2'b00);
    check("R7 masked", {7'b0, irq}, 8'h00);
    wr(AD_MASK, 8'h02);
    check("R7 asserted", {7'b0, irq}, 8'h01);
    setctl(1'b0, 1'b0, 2'b00);
    check("R7 gie off", {7'b0, irq}, 8'h00);
    setctl(1'b0, 1'b1, 2'b00);
    wr(AD_MASK, 8'h01);
    check("R7 other mask", {7'b0, irq}, 8'h00);

    // R5: write-one clear
    wr(AD_MASK, 8'h03);
    wr(AD_FLAG, 8'h02);
    rd(AD_FLAG, d);
    check("R5 w1c", d, 8'h00);
    check("R7 irq after clear", {7'b0, irq}, 8'h00);

    // R9: direction back to input
    wr(AD_DIR, 8'h00);
    check("R9 oe off", {7'b0, cmp_oe}, 8'h00);

    summary();
  end
endmodule